// File: doc/BRIEF.md
# External Pin Wakeup Detector

This block watches a bank of external wakeup pins while the device sits in a low-power state. Each pin has its own two-bit edge selector that decides whether rising edges, falling edges, both, or neither count as an event. A counted event latches a sticky per-pin source flag. Any latched flag on a pin that is still armed raises a wake request towards the power sequencer. A latched flag on a pin whose interrupt enable is set raises an interrupt request, but only once the device has left low power. While the device is still in low power, the request is held back and the flag keeps it pending.

Pins are sampled on ticks taken from one of two oscillator-derived strobes: a fast one or a slow one, chosen by a select input. All state lives in the system clock domain. Each strobe marks one sampling instant of its oscillator. Software reads the flags and clears them with a write-one-to-clear strobe.

Top module: `pin_wake_detect`

## Requirements
- R1: While rst_n is low, flags, wake_req and irq are all 0.
- R2: A pin whose edge field edge_en[2i+1:2i] is 00 never sets its flag, whatever its pin does.
- R3: Field value 01 sets the flag on a rising pin edge only; a falling edge leaves the flag clear.
- R4: Field value 10 sets the flag on a falling pin edge only; a rising edge leaves the flag clear.
- R5: Field value 11 sets the flag on both rising and falling edges.
- R6: Sampling happens only on cycles where the selected strobe is high (clk_sel=1 selects tick_fast, clk_sel=0 selects tick_slow). Flags never newly set on a cycle without a selected strobe.
- R7: With a selected strobe on every cycle, a pin change presented before clock edge k shows in flags after edge k+2 (two synchronizer samples, then the compare).
- R8: A clock edge with clr_we=1 clears every flag whose bit in clr_data is 1 and leaves the others unchanged.
- R9: When an event and a clear hit the same flag on the same edge, the flag stays set.
- R10: wake_req is registered. After each edge it equals the OR, taken one cycle earlier, of all flags whose pin edge field was nonzero.
- R11: irq is registered. After each edge it is 1 exactly when, on the previous cycle, lp_active was 0 and some flag with irq_en set was 1. A pending flag raises irq once lp_active falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 1 | 1 = sample on tick_fast, 0 = sample on tick_slow |
| tick_fast | input | 1 | Sampling strobe from the fast oscillator |
| tick_slow | input | 1 | Sampling strobe from the slow oscillator |
| pins | input | NPINS | External wakeup pins |
| edge_en | input | 2*NPINS | Per-pin edge field: 00 off, 01 rise, 10 fall, 11 both |
| irq_en | input | NPINS | Per-pin interrupt enable |
| lp_active | input | 1 | High while the device is still in low power |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_data | input | NPINS | Bits to clear when clr_we is high |
| flags | output | NPINS | Sticky per-pin source flags |
| wake_req | output | 1 | Wake request to the power sequencer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default of 32 pins. This lets one run give the four edge encodings their own pins side by side, keep a separate pin for each of the clear, collision and disarm cases, and still hold the whole flag vector in a single 32-bit compare. Both strobe sources are driven by the bench. The slow source is pulsed sparsely, which brings into reach the case where a pin has changed but no selected sample has yet been taken.

// File: rtl/pin_wake_detect.sv
module pin_wake_detect #(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_sel,
  input  logic               tick_fast,
  input  logic               tick_slow,
  input  logic [NPINS-1:0]   pins,
  input  logic [2*NPINS-1:0] edge_en,
  input  logic [NPINS-1:0]   irq_en,
  input  logic               lp_active,
  input  logic               clr_we,
  input  logic [NPINS-1:0]   clr_data,
  output logic [NPINS-1:0]   flags,
  output logic               wake_req,
  output logic               irq
);

  logic             samp;
  logic [NPINS-1:0] sync0, sync1, prev;
  logic [NPINS-1:0] rise_en, fall_en, armed, hit;

  assign samp = clk_sel ? tick_fast : tick_slow;

  for (genvar i = 0; i < NPINS; i++) begin : g_field
    assign rise_en[i] = edge_en[2*i];
    assign fall_en[i] = edge_en[2*i+1];
  end

  assign armed = rise_en | fall_en;
  assign hit   = {NPINS{samp}} &
                 ((sync1 & ~prev & rise_en) | (~sync1 & prev & fall_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0    <= '0;
      sync1    <= '0;
      prev     <= '0;
      flags    <= '0;
      wake_req <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (samp) begin
        sync0 <= pins;
        sync1 <= sync0;
        prev  <= sync1;
      end
      flags    <= (flags & ~({NPINS{clr_we}} & clr_data)) | hit;
      wake_req <= |(flags & armed);
      irq      <= ~lp_active & (|(flags & irq_en));
    end
  end

endmodule

// File: rtl/pin_wake_detect_chk.sv
module pin_wake_detect_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_sel,
  input logic             tick_fast,
  input logic             tick_slow,
  input logic [NPINS-1:0] irq_en,
  input logic             lp_active,
  input logic             clr_we,
  input logic [NPINS-1:0] clr_data,
  input logic [NPINS-1:0] flags,
  input logic             wake_req,
  input logic             irq
);

  logic sel_tick;
  assign sel_tick = clk_sel ? tick_fast : tick_slow;

  // R6
  a_r6_no_new_flag_untick: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_tick |=> ((flags & ~$past(flags)) == '0));

  // R8
  a_r8_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !sel_tick) |=> ((flags & $past(clr_data)) == '0));

  // R10
  a_r10_wake_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(|flags));

  // R11
  a_r11_lp_holds_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lp_active) |-> !irq);

  // R11
  a_r11_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(flags & irq_en)));

endmodule

bind pin_wake_detect pin_wake_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick_fast(tick_fast),
  .tick_slow(tick_slow), .irq_en(irq_en), .lp_active(lp_active),
  .clr_we(clr_we), .clr_data(clr_data), .flags(flags),
  .wake_req(wake_req), .irq(irq)
);

// File: tb/pin_wake_detect_tb_top.sv
module pin_wake_detect_tb_top;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_sel = 1'b1;
  logic          tick_fast = 1'b1;
  logic          tick_slow = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [2*NP-1:0] edge_en = '0;
  logic [NP-1:0] irq_en = '0;
  logic          lp_active = 1'b0;
  logic          clr_we = 1'b0;
  logic [NP-1:0] clr_data = '0;
  logic [NP-1:0] flags;
  logic          wake_req, irq;

  always #5 clk = ~clk;

  pin_wake_detect #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .pins(pins), .edge_en(edge_en), .irq_en(irq_en),
    .lp_active(lp_active), .clr_we(clr_we), .clr_data(clr_data),
    .flags(flags), .wake_req(wake_req), .irq(irq)
  );

  int nchk = 0, nfail = 0;
  string cur_req = "R1";

  bit hist[NP][$];
  bit [NP-1:0] flags_m;
  bit wake_m, irq_m;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) hist[p] = '{1'b0, 1'b0, 1'b0};
    flags_m = '0; wake_m = 1'b0; irq_m = 1'b0;
  endtask

  task automatic model_step();
    bit [NP-1:0] nf;
    bit w, q, s;
    nf = flags_m; w = 1'b0; q = 1'b0;
    s = clk_sel ? tick_fast : tick_slow;
    for (int p = 0; p < NP; p++) begin
      if (flags_m[p] && edge_en[2*p +: 2] != 2'b00) w = 1'b1;
      if (flags_m[p] && irq_en[p]) q = 1'b1;
    end
    if (clr_we) nf = nf & ~clr_data;
    if (s) begin
      for (int p = 0; p < NP; p++) begin
        bit cur, prv;
        logic [1:0] code;
        cur = hist[p][1]; prv = hist[p][2]; code = edge_en[2*p +: 2];
        if (cur != prv && ((cur && code[0]) || (!cur && code[1]))) nf[p] = 1'b1;
        hist[p].push_front(pins[p]);
        void'(hist[p].pop_back());
      end
    end
    flags_m = nf; wake_m = w; irq_m = q && !lp_active;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({cur_req, " flags vs model"}, flags, flags_m);
    chk({cur_req, " wake_req vs model"}, {31'b0, wake_req}, {31'b0, wake_m});
    chk({cur_req, " irq vs model"}, {31'b0, irq}, {31'b0, irq_m});
  endtask

  task automatic ncyc(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_data = '1;
    cyc();
    clr_we = 1'b0; clr_data = '0;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int p = 4; p < NP; p++) edge_en[2*p +: 2] = 2'b01;
    edge_en[1:0] = 2'b00;
    edge_en[3:2] = 2'b01;
    edge_en[5:4] = 2'b10;
    edge_en[7:6] = 2'b11;
    irq_en = 32'h8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 flags in reset", flags, '0);
    chk("R1 wake_req in reset", {31'b0, wake_req}, 0);
    chk("R1 irq in reset", {31'b0, irq}, 0);
    rst_n = 1'b1;
    model_reset();

    cur_req = "R7";
    pins[1] = 1'b1;
    ncyc(2);
    chk("R7 flag not yet after two edges", {31'b0, flags[1]}, 0);
    cyc();
    chk("R7 R3 flag after third edge", {31'b0, flags[1]}, 1);
    cur_req = "R10";
    cyc();
    chk("R10 wake_req follows flag", {31'b0, wake_req}, 1);

    cur_req = "R5";
    pins[3] = 1'b1;
    ncyc(3);
    chk("R5 rising on both-edge pin", {31'b0, flags[3]}, 1);
    cur_req = "R8";
    clr_we = 1'b1; clr_data = 32'h2;
    cyc();
    clr_we = 1'b0; clr_data = '0;
    chk("R8 partial clear", flags, 32'h8);

    cur_req = "R11";
    lp_active = 1'b1;
    ncyc(2);
    chk("R11 irq held in low power", {31'b0, irq}, 0);
    lp_active = 1'b0;
    cyc();
    chk("R11 irq after recovery", {31'b0, irq}, 1);
    clear_all();
    chk("R10 wake_req drops after clear", {31'b0, wake_req}, 0);
    chk("R11 irq drops after clear", {31'b0, irq}, 0);

    cur_req = "R5";
    pins[3] = 1'b0;
    ncyc(3);
    chk("R5 falling on both-edge pin", {31'b0, flags[3]}, 1);
    clear_all();

    cur_req = "R3";
    pins[1] = 1'b0;
    ncyc(4);
    chk("R3 falling ignored on rise pin", {31'b0, flags[1]}, 0);

    cur_req = "R4";
    pins[2] = 1'b1;
    ncyc(4);
    chk("R4 rising ignored on fall pin", {31'b0, flags[2]}, 0);
    pins[2] = 1'b0;
    ncyc(3);
    chk("R4 falling sets fall pin", {31'b0, flags[2]}, 1);
    clear_all();

    cur_req = "R2";
    pins[0] = 1'b1;
    ncyc(4);
    pins[0] = 1'b0;
    ncyc(4);
    chk("R2 disabled pin flags", flags, '0);
    chk("R2 disabled pin wake_req", {31'b0, wake_req}, 0);

    cur_req = "R10";
    pins[5] = 1'b1;
    ncyc(3);
    chk("R10 flag on pin 5", {31'b0, flags[5]}, 1);
    edge_en[11:10] = 2'b00;
    ncyc(2);
    chk("R10 disarmed pin gives no wake", {31'b0, wake_req}, 0);
    chk("R10 flag itself stays set", {31'b0, flags[5]}, 1);
    edge_en[11:10] = 2'b01;
    clear_all();

    cur_req = "R9";
    pins[4] = 1'b1;
    ncyc(2);
    clr_we = 1'b1; clr_data = 32'h10;
    cyc();
    clr_we = 1'b0; clr_data = '0;
    chk("R9 event beats clear", {31'b0, flags[4]}, 1);
    clear_all();
    chk("R8 clear after collision", flags, '0);

    cur_req = "R6";
    clk_sel = 1'b0; tick_fast = 1'b1; tick_slow = 1'b0;
    pins[6] = 1'b1;
    ncyc(5);
    chk("R6 fast ticks ignored when slow selected", {31'b0, flags[6]}, 0);
    for (int k = 0; k < 3; k++) begin
      tick_slow = 1'b1;
      cyc();
      tick_slow = 1'b0;
      cyc();
    end
    chk("R6 slow ticks sample", {31'b0, flags[6]}, 1);
    clk_sel = 1'b1; tick_fast = 1'b0;
    pins[7] = 1'b1;
    ncyc(5);
    chk("R6 no sample without fast tick", {31'b0, flags[7]}, 0);
    tick_fast = 1'b1;
    ncyc(3);
    chk("R6 fast tick resumes sampling", {31'b0, flags[7]}, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule